// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block collects four event sources for a small 8-bit processor core and turns them into an interrupt request and a wake-up request. The sources are an external pin, a timer wrap event, a change detector over a group of port inputs, and a completion pulse from the non-volatile data-memory writer. Each source has a flag and an enable bit. An event always sets its flag, and the flag stays set until software writes it low. The external pin is edge sensitive, and a control bit picks which edge counts.

The enable bit of each source gates only the request outputs, not the flag. The wake-up output is the OR over all sources of flag AND enable. It ignores the global enable, so a sleeping core wakes whenever an enabled source has a pending flag. The interrupt request is the same OR qualified by the global enable. The global enable therefore decides whether the core jumps to its handler after waking or carries on in line. The block saves no register context; that is left to the core and its software.

The port change detector compares the synchronized port inputs against a snapshot. The snapshot is refreshed whenever the core reads the port, so a read ends the mismatch. The external pin and the port inputs each pass through a two-flop synchronizer before detection.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the control register reads 0, the flag register reads 0, and both `irq_req` and `wake_req` are low.
- R2: When the edge select (control bit 4) is 1, a rising edge on `ext_pin` sets flag bit 0 on the third rising clock edge after the pin changes. A falling edge does not set the flag.
- R3: When the edge select is 0, a falling edge on `ext_pin` sets flag bit 0 with the same three-clock latency. A rising edge does not set the flag.
- R4: A one-cycle `tmr_ovf` pulse sets flag bit 1 at the next clock edge.
- R5: If the synchronized `port_in` differs from the snapshot, flag bit 2 is set three clocks after the input changes. A cycle with `port_rd` high loads the snapshot. After that, the same input value no longer sets the flag.
- R6: A one-cycle `wr_done` pulse sets flag bit 3 at the next clock edge.
- R7: A flag keeps its value until a register write with `reg_addr`=1 loads `reg_wdata[3:0]` into the flags. Writing 0 to a bit clears it.
- R8: If a hardware set event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R9: `wake_req` is high exactly when some flag bit and its enable bit (control bits 3:0, same bit order as the flags) are both 1. It does not depend on the global enable.
- R10: `irq_req` is high exactly when `wake_req` is high and the global enable (control bit 5) is 1.
- R11: A source whose enable bit is 0 still sets its flag, but it raises neither request output.
- R12: A register write with `reg_addr`=0 loads `reg_wdata[5:0]` into the control register. Both registers read back on `rd_ctrl` and `rd_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_in | input | PORT_W | Monitored port inputs, asynchronous |
| port_rd | input | 1 | Core reads the port; loads the snapshot |
| tmr_ovf | input | 1 | Timer wrap pulse, one cycle |
| wr_done | input | 1 | Data-memory write complete pulse, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Selects control (0) or flags (1) |
| reg_wdata | input | 6 | Write data |
| rd_ctrl | output | 6 | Control register: [5] global enable, [4] edge select, [3:0] enables |
| rd_flags | output | 4 | Flags: [0] ext, [1] timer, [2] port, [3] memory write |
| irq_req | output | 1 | Interrupt request to the core |
| wake_req | output | 1 | Wake-up request out of sleep |

## Verification
A hardware flag set and a software flag write can land on the same clock edge, and that overlap is the case the bench forces on purpose. It raises `tmr_ovf` in the same cycle that it writes the flag register with all zeros. On the next cycle, flag bit 1 must read 1 and every other flag must read 0. A second overlap, port read against a still-pending mismatch, is checked the same way: the flag must survive the read, and once it is cleared it must stay clear.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC    = 4;
    localparam int CTRL_W  = NSRC + 2;
    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_PRT = 2;
    localparam int SRC_MEM = 3;
    localparam int BIT_POL = NSRC;
    localparam int BIT_GIE = NSRC + 1;

    typedef struct packed {
        logic            gie;
        logic            pol;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] flag;
    } irq_state_t;
endpackage

// File: rtl/irq_sync2.sv
module irq_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    input  logic rise_sel,
    output logic hit
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign hit = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);

    // R2/R3: one level change gives one detection; no two in a row
    a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && $stable(rise_sel)) |=> !hit);
endmodule

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         capture,
    output logic         diff
);
    logic [W-1:0] snap_d, snap_q;

    always_comb begin
        snap_d = snap_q;
        if (capture) snap_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign diff = (lvl != snap_q);

    // R5: the snapshot moves only on a port read
    a_r5_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(snap_q));
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              tmr_ovf,
    input  logic              wr_done,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] rd_ctrl,
    output logic [NSRC-1:0]   rd_flags,
    output logic              irq_req,
    output logic              wake_req
);
    localparam int SYNC_W = PORT_W + 1;

    logic [SYNC_W-1:0] raw_in, sync_out;
    logic              ext_hit, port_diff;
    logic [NSRC-1:0]   set_vec;
    irq_state_t        st_d, st_q;

    assign raw_in = {port_in, ext_pin};

    irq_sync2 #(.W(SYNC_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
    );

    irq_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sync_out[0]),
        .rise_sel(st_q.pol), .hit(ext_hit)
    );

    irq_chg_det #(.W(PORT_W)) u_chg (
        .clk(clk), .rst_n(rst_n), .lvl(sync_out[SYNC_W-1:1]),
        .capture(port_rd), .diff(port_diff)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SRC_EXT] = ext_hit;
        set_vec[SRC_TMR] = tmr_ovf;
        set_vec[SRC_PRT] = port_diff;
        set_vec[SRC_MEM] = wr_done;
    end

    always_comb begin
        st_d = st_q;
        if (reg_wr && !reg_addr) begin
            st_d.gie = reg_wdata[BIT_GIE];
            st_d.pol = reg_wdata[BIT_POL];
            st_d.en  = reg_wdata[NSRC-1:0];
        end
        if (reg_wr && reg_addr) st_d.flag = reg_wdata[NSRC-1:0];
        st_d.flag = st_d.flag | set_vec;  // hardware set wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_ctrl  = {st_q.gie, st_q.pol, st_q.en};
    assign rd_flags = st_q.flag;
    assign wake_req = |(st_q.flag & st_q.en);
    assign irq_req  = st_q.gie & wake_req;

    // R7: without a write, no flag bit drops
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((rd_flags & $past(rd_flags)) == $past(rd_flags)));
    // R8: timer event sets its flag even against a clearing write
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> rd_flags[SRC_TMR]);
    // R6: write-complete pulse lands in its flag
    a_r6_mem_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> rd_flags[SRC_MEM]);
    // R10: a request implies a wake condition
    a_r10_irq_implies_wake: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> wake_req);
    // R9: with all enables low there is no wake
    a_r9_wake_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl[NSRC-1:0] == '0) |-> !wake_req);
endmodule

// File: tb/irq_flag_ctrl_test.sv
`timescale 1ns/1ps
module irq_flag_ctrl_test;
    localparam int PW = 4;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          ext_pin = 0;
    logic [PW-1:0] port_in = '0;
    logic          port_rd = 0, tmr_ovf = 0, wr_done = 0;
    logic          reg_wr = 0, reg_addr = 0;
    logic [5:0]    reg_wdata = '0;
    logic [5:0]    rd_ctrl;
    logic [3:0]    rd_flags;
    logic          irq_req, wake_req;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_flag_ctrl #(.PORT_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
        .port_rd(port_rd), .tmr_ovf(tmr_ovf), .wr_done(wr_done),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rd_ctrl(rd_ctrl), .rd_flags(rd_flags),
        .irq_req(irq_req), .wake_req(wake_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic a, input logic [5:0] v);
        reg_wr = 1; reg_addr = a; reg_wdata = v;
        step(1);
        reg_wr = 0;
    endtask

    task automatic t_reset;
        chk("R1 ctrl", rd_ctrl, 0);
        chk("R1 flags", rd_flags, 0);
        chk("R1 irq", irq_req, 0);
        chk("R1 wake", wake_req, 0);
    endtask

    task automatic t_ctrl_rw;
        wr_reg(0, 6'h2A);
        chk("R12 ctrl readback", rd_ctrl, 6'h2A);
        wr_reg(0, 6'h00);
        chk("R12 ctrl zero", rd_ctrl, 0);
    endtask

    task automatic t_ext_rise;
        wr_reg(0, 6'h10);  // rising edge select
        ext_pin = 1;
        step(2);
        chk("R2 latency not yet", rd_flags[0], 0);
        step(1);
        chk("R2 rise sets", rd_flags[0], 1);
        wr_reg(1, 6'h0);
        ext_pin = 0;
        step(5);
        chk("R2 fall ignored", rd_flags[0], 0);
    endtask

    task automatic t_ext_fall;
        wr_reg(0, 6'h00);  // falling edge select
        ext_pin = 1;
        step(5);
        chk("R3 rise ignored", rd_flags[0], 0);
        ext_pin = 0;
        step(2);
        chk("R3 latency not yet", rd_flags[0], 0);
        step(1);
        chk("R3 fall sets", rd_flags[0], 1);
        wr_reg(1, 6'h0);
    endtask

    task automatic t_timer;
        tmr_ovf = 1; step(1); tmr_ovf = 0;
        chk("R4 timer flag", rd_flags, 4'h2);
        step(3);
        chk("R7 stays set", rd_flags, 4'h2);
        wr_reg(1, 6'h0);
        chk("R7 write clears", rd_flags, 0);
    endtask

    task automatic t_port;
        port_in = 4'h5;
        step(2);
        chk("R5 latency not yet", rd_flags[2], 0);
        step(1);
        chk("R5 change sets", rd_flags[2], 1);
        port_rd = 1; step(1); port_rd = 0;
        chk("R5 flag kept over read", rd_flags[2], 1);
        wr_reg(1, 6'h0);
        step(4);
        chk("R5 after read no set", rd_flags[2], 0);
        port_in = 4'h4;
        step(3);
        chk("R5 new change sets", rd_flags[2], 1);
        port_rd = 1; step(1); port_rd = 0;
        wr_reg(1, 6'h0);
    endtask

    task automatic t_mem;
        wr_done = 1; step(1); wr_done = 0;
        chk("R6 mem flag", rd_flags, 4'h8);
        chk("R11 no wake disabled", wake_req, 0);
        chk("R11 no irq disabled", irq_req, 0);
        wr_reg(0, 6'h08);
        chk("R9 wake without gie", wake_req, 1);
        chk("R10 no irq without gie", irq_req, 0);
        wr_reg(0, 6'h28);
        chk("R10 irq with gie", irq_req, 1);
        wr_reg(0, 6'h24);
        chk("R9 other enable no wake", wake_req, 0);
        chk("R10 no irq", irq_req, 0);
        wr_reg(1, 6'h0);
        wr_reg(0, 6'h00);
    endtask

    task automatic t_collide;
        wr_reg(1, 6'h9);
        chk("R7 sw write loads", rd_flags, 4'h9);
        tmr_ovf = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 6'h0;
        step(1);
        tmr_ovf = 0; reg_wr = 0;
        chk("R8 set wins over clear", rd_flags, 4'h2);
        wr_reg(1, 6'h0);
    endtask

    initial begin
        step(2);
        rst_n = 1;
        step(1);
        t_reset();
        t_ctrl_rw();
        t_ext_rise();
        t_ext_fall();
        t_timer();
        t_port();
        t_mem();
        t_collide();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule